// File: doc/BRIEF.md
# Bang-Bang Clock Phase Detector with Vote Averaging

The block judges whether a recovered clock is early or late against serial NRZ data. For every bit it looks at three samples. The first is the centre of the bit before, which the block stores itself. The second is the sample taken where the data should cross over. The third is the centre of the present bit. From these it decides one of three things: the clock is early, the clock is late, or there is nothing to tell. It reports each decision as a one-cycle pulse.

The decisions feed a saturating signed accumulator. The accumulator leaks toward zero at a programmable rate. Its value is clamped to a programmable magnitude and leaves the block as the control word that steers the oscillator. The present-bit centre sample is also registered and output as the retimed data.

The samplers, the oscillator and frequency acquisition sit outside the block.

A two-state tracker controls the start-up behaviour. `ST_EMPTY` means no previous bit has been stored yet, and `ST_TRACK` means it has. The tracker moves from `ST_EMPTY` to `ST_TRACK` on the first qualified sample set after reset and then stays in `ST_TRACK` until the next reset.

Top module: `bbpd_avg_top`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, `ctrl_word`, `ctrl_clamped`, both vote outputs, `dout` and the stored previous bit. The first sample set with `smp_valid` high after reset casts no vote and leaves the accumulator unchanged.
- R2: Take a qualified sample set where the stored previous bit differs from `smp_curr` and `smp_xing` equals `smp_curr`. On the next cycle `vote_late` is 1 for one cycle and the accumulator has decreased by one.
- R3: Take a qualified sample set where the stored previous bit differs from `smp_curr` and `smp_xing` equals the previous bit. On the next cycle `vote_early` is 1 for one cycle and the accumulator has increased by one.
- R4: A qualified sample set where the stored previous bit equals `smp_curr` is undetermined, whatever `smp_xing` is. It casts no vote and leaves the accumulator unchanged.
- R5: When `smp_valid` is 0, no vote is cast and the accumulator, `dout` and the stored previous bit all keep their values.
- R6: `dout` takes the value of `smp_curr` on each edge where `smp_valid` is 1. The new value is visible in the following cycle.
- R7: The accumulator saturates at +(2^(ACC_W-1)-1) and at -(2^(ACC_W-1)-1). It never wraps, and the most negative code never appears.
- R8: Every qualified sample set is counted. When `cfg_leak_period` is not zero, every `cfg_leak_period`-th set first applies its vote (saturated) and then applies a leak. The leak replaces the magnitude m with m - (m >> `cfg_leak_shift`) and keeps the sign, so a shift of 0 clears the accumulator. When `cfg_leak_period` is 0, there is no leak.
- R9: `ctrl_word` equals the accumulator clamped to ±`cfg_limit`. `ctrl_clamped` is 1 exactly when the accumulator magnitude exceeds `cfg_limit`. Both outputs follow `cfg_limit` combinationally.
- R10: `vote_early` and `vote_late` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Qualifies the sample set of this cycle |
| smp_xing | input | 1 | Sample at the expected crossover point |
| smp_curr | input | 1 | Sample at the centre of the present bit |
| cfg_leak_shift | input | SHIFT_W | Right-shift amount of the leak |
| cfg_leak_period | input | CNT_W | Qualified sets between leaks; 0 turns the leak off |
| cfg_limit | input | ACC_W-1 | Magnitude limit of the control word |
| vote_early | output | 1 | One-cycle pulse: clock early |
| vote_late | output | 1 | One-cycle pulse: clock late |
| ctrl_word | output | ACC_W | Signed, clamped control word |
| ctrl_clamped | output | 1 | The clamp is active |
| dout | output | 1 | Retimed data |

## Verification
A vote and a leak can land on the same edge, and the result depends on which is applied first. The bench provokes this with leak periods of 4 and 1. The expected values assume that the vote goes in first and the leak is then taken from the saturated sum. Saturation and clamping can also hold at the same time. The bench drives the accumulator into both rails and then moves the limit underneath it, checking that the word and the flag follow the limit while the stored value does not change.

// File: rtl/bbpd_pkg.sv
`timescale 1ns/1ps
package bbpd_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_t;

    typedef enum logic [1:0] {
        VOTE_NONE  = 2'd0,
        VOTE_EARLY = 2'd1,
        VOTE_LATE  = 2'd2
    } vote_t;

endpackage

// File: rtl/bbpd_classify.sv
`timescale 1ns/1ps
module bbpd_classify
    import bbpd_pkg::*;
(
    input  logic  armed,
    input  logic  prev_bit,
    input  logic  xing_bit,
    input  logic  curr_bit,
    output vote_t vote
);

    // Having no transition outranks both directions: the crossover sample
    // means nothing when the data did not change.
    always_comb begin
        vote = VOTE_NONE;
        if (armed && (prev_bit != curr_bit)) begin
            if (xing_bit == curr_bit) begin
                vote = VOTE_LATE;
            end else begin
                vote = VOTE_EARLY;
            end
        end
    end

endmodule

// File: rtl/bbpd_leak_acc.sv
`timescale 1ns/1ps
module bbpd_leak_acc
    import bbpd_pkg::*;
#(
    parameter int ACC_W   = 8,
    parameter int SHIFT_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      upd,
    input  vote_t                     vote,
    input  logic                      leak_now,
    input  logic [SHIFT_W-1:0]        leak_shift,
    output logic signed [ACC_W-1:0]   acc
);

    localparam logic signed [ACC_W:0] HI_X = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] LO_X = -HI_X;

    logic signed [ACC_W:0]   delta;
    logic signed [ACC_W:0]   sum_x;
    logic signed [ACC_W-1:0] sat_v;
    logic [ACC_W-1:0]        mag;
    logic [ACC_W-1:0]        rem;
    logic signed [ACC_W-1:0] leaked_v;
    logic signed [ACC_W-1:0] acc_d;

    always_comb begin
        unique case (vote)
            VOTE_EARLY: delta = {{ACC_W{1'b0}}, 1'b1};
            VOTE_LATE:  delta = {(ACC_W+1){1'b1}};
            default:    delta = '0;
        endcase
    end

    // Vote first, saturate symmetrically.
    always_comb begin
        sum_x = {acc[ACC_W-1], acc} + delta;
        if (sum_x > HI_X) begin
            sat_v = HI_X[ACC_W-1:0];
        end else if (sum_x < LO_X) begin
            sat_v = LO_X[ACC_W-1:0];
        end else begin
            sat_v = sum_x[ACC_W-1:0];
        end
    end

    // Leak on the magnitude so both signs decay alike.
    always_comb begin
        mag = sat_v[ACC_W-1] ? (~sat_v + 1'b1) : sat_v;
        rem = mag - (mag >> leak_shift);
        leaked_v = sat_v[ACC_W-1] ? (~rem + 1'b1) : rem;
    end

    always_comb begin
        acc_d = acc;
        if (upd) begin
            acc_d = leak_now ? leaked_v : sat_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            acc <= acc_d;
        end
    end

endmodule

// File: rtl/bbpd_clamp.sv
`timescale 1ns/1ps
module bbpd_clamp #(
    parameter int ACC_W = 8
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [ACC_W-2:0]        limit,
    output logic signed [ACC_W-1:0] ctrl,
    output logic                    hit
);

    logic signed [ACC_W:0] a_x;
    logic signed [ACC_W:0] hi_x;
    logic signed [ACC_W:0] lo_x;

    always_comb begin
        a_x  = {acc[ACC_W-1], acc};
        hi_x = {2'b00, limit};
        lo_x = -hi_x;
        if (a_x > hi_x) begin
            ctrl = hi_x[ACC_W-1:0];
            hit  = 1'b1;
        end else if (a_x < lo_x) begin
            ctrl = lo_x[ACC_W-1:0];
            hit  = 1'b1;
        end else begin
            ctrl = acc;
            hit  = 1'b0;
        end
    end

endmodule

// File: rtl/bbpd_avg_top.sv
`timescale 1ns/1ps
module bbpd_avg_top
    import bbpd_pkg::*;
#(
    parameter int ACC_W   = 8,
    parameter int SHIFT_W = 3,
    parameter int CNT_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic                    smp_xing,
    input  logic                    smp_curr,
    input  logic [SHIFT_W-1:0]      cfg_leak_shift,
    input  logic [CNT_W-1:0]        cfg_leak_period,
    input  logic [ACC_W-2:0]        cfg_limit,
    output logic                    vote_early,
    output logic                    vote_late,
    output logic signed [ACC_W-1:0] ctrl_word,
    output logic                    ctrl_clamped,
    output logic                    dout
);

    trk_state_t state_q;
    trk_state_t state_d;

    logic              armed;
    logic              prev_q;
    vote_t             vote;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic [CNT_W:0]    cnt_inc;
    logic              leak_hit;
    logic signed [ACC_W-1:0] acc;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ST_EMPTY -> ST_TRACK on the first qualified set.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (smp_valid) state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State-dependent outputs.
    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            ST_EMPTY: armed = 1'b0;
            ST_TRACK: armed = smp_valid;
            default:  armed = 1'b0;
        endcase
    end

    bbpd_classify u_cls (
        .armed    (armed),
        .prev_bit (prev_q),
        .xing_bit (smp_xing),
        .curr_bit (smp_curr),
        .vote     (vote)
    );

    // Leak cadence counted in qualified sets.
    always_comb begin
        cnt_inc  = {1'b0, cnt_q} + 1'b1;
        leak_hit = smp_valid && (cfg_leak_period != '0) &&
                   (cnt_inc >= {1'b0, cfg_leak_period});
        cnt_d    = cnt_q;
        if (smp_valid) begin
            if (cfg_leak_period == '0 || leak_hit) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            prev_q     <= 1'b0;
            dout       <= 1'b0;
            vote_early <= 1'b0;
            vote_late  <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            vote_early <= (vote == VOTE_EARLY);
            vote_late  <= (vote == VOTE_LATE);
            if (smp_valid) begin
                prev_q <= smp_curr;
                dout   <= smp_curr;
            end
        end
    end

    bbpd_leak_acc #(
        .ACC_W   (ACC_W),
        .SHIFT_W (SHIFT_W)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .upd        (smp_valid),
        .vote       (vote),
        .leak_now   (leak_hit),
        .leak_shift (cfg_leak_shift),
        .acc        (acc)
    );

    bbpd_clamp #(
        .ACC_W (ACC_W)
    ) u_clamp (
        .acc   (acc),
        .limit (cfg_limit),
        .ctrl  (ctrl_word),
        .hit   (ctrl_clamped)
    );

endmodule

// File: rtl/bbpd_avg_chk.sv
`timescale 1ns/1ps
module bbpd_avg_chk #(
    parameter int ACC_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_valid,
    input logic                    smp_curr,
    input logic [ACC_W-2:0]        cfg_limit,
    input logic                    vote_early,
    input logic                    vote_late,
    input logic signed [ACC_W-1:0] ctrl_word,
    input logic                    ctrl_clamped,
    input logic                    dout
);

    localparam logic signed [ACC_W-1:0] MIN_CODE = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W:0] lim_x;
    logic signed [ACC_W:0] ctrl_x;
    logic                  rst_d = 1'b0;

    assign lim_x  = {2'b00, cfg_limit};
    assign ctrl_x = {ctrl_word[ACC_W-1], ctrl_word};

    always @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            AST_RESET_CLEARS: assert (ctrl_word == '0 && !vote_early && !vote_late && !dout && !ctrl_clamped); // R1
        end
    end

    AST_VOTE_EXCL: assert property (@(posedge clk) disable iff (rst) !(vote_early && vote_late)); // R10
    AST_IDLE_NO_VOTE: assert property (@(posedge clk) disable iff (rst) !smp_valid |=> (!vote_early && !vote_late)); // R5
    AST_IDLE_HOLD_CTRL: assert property (@(posedge clk) disable iff (rst) (!smp_valid && $stable(cfg_limit)) |=> ((ctrl_word == $past(ctrl_word)) || (cfg_limit != $past(cfg_limit)))); // R5
    AST_VOTE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) (vote_early || vote_late) |-> $past(smp_valid)); // R2 R3
    AST_DOUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst) smp_valid |=> (dout == $past(smp_curr))); // R6
    AST_CTRL_IN_LIMIT: assert property (@(posedge clk) disable iff (rst) (ctrl_x <= lim_x) && (ctrl_x >= -lim_x)); // R9
    AST_FLAG_AT_RAIL: assert property (@(posedge clk) disable iff (rst) ctrl_clamped |-> ((ctrl_x == lim_x) || (ctrl_x == -lim_x))); // R9
    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (rst) ctrl_word != MIN_CODE); // R7

endmodule

bind bbpd_avg_top bbpd_avg_chk #(
    .ACC_W (ACC_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .smp_curr     (smp_curr),
    .cfg_limit    (cfg_limit),
    .vote_early   (vote_early),
    .vote_late    (vote_late),
    .ctrl_word    (ctrl_word),
    .ctrl_clamped (ctrl_clamped),
    .dout         (dout)
);

// File: tb/sim_bbpd_avg_top.sv
`timescale 1ns/1ps
module sim_bbpd_avg_top;

    localparam int ACC_W   = 8;
    localparam int SHIFT_W = 3;
    localparam int CNT_W   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic smp_xing = 1'b0;
    logic smp_curr = 1'b0;
    logic [SHIFT_W-1:0] cfg_leak_shift = '0;
    logic [CNT_W-1:0]   cfg_leak_period = '0;
    logic [ACC_W-2:0]   cfg_limit = 7'd127;
    logic vote_early;
    logic vote_late;
    logic signed [ACC_W-1:0] ctrl_word;
    logic ctrl_clamped;
    logic dout;

    int errors = 0;
    int checks = 0;
    int exp_acc = 0;
    logic tb_last = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    bbpd_avg_top #(
        .ACC_W   (ACC_W),
        .SHIFT_W (SHIFT_W),
        .CNT_W   (CNT_W)
    ) u0 (
        .clk             (clk),
        .rst             (rst),
        .smp_valid       (smp_valid),
        .smp_xing        (smp_xing),
        .smp_curr        (smp_curr),
        .cfg_leak_shift  (cfg_leak_shift),
        .cfg_leak_period (cfg_leak_period),
        .cfg_limit       (cfg_limit),
        .vote_early      (vote_early),
        .vote_late       (vote_late),
        .ctrl_word       (ctrl_word),
        .ctrl_clamped    (ctrl_clamped),
        .dout            (dout)
    );

    // Fields: {xing, curr, expect_early, expect_late}; the first row follows reset.
    localparam logic [3:0] TBL [10] = '{
        4'b0100, 4'b1010, 4'b0110, 4'b1100, 4'b0001,
        4'b1101, 4'b0100, 4'b0001, 4'b0110, 4'b1010
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic v, input logic x, input logic c);
        smp_valid = v;
        smp_xing  = x;
        smp_curr  = c;
        if (v) tb_last = c;
        @(negedge clk);
    endtask

    task automatic bit_early();
        step(1'b1, tb_last, ~tb_last);
    endtask

    task automatic bit_late();
        step(1'b1, ~tb_last, ~tb_last);
    endtask

    task automatic bit_flat();
        step(1'b1, ~tb_last, tb_last);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        tb_last = 1'b0;
        exp_acc = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 ctrl after reset", int'(ctrl_word), 0);
        check("R1 votes after reset", int'({vote_early, vote_late}), 0);
        check("R1 dout after reset", int'(dout), 0);
        check("R1 clamp flag after reset", int'(ctrl_clamped), 0);

        // Table walk: no leak, wide limit.
        for (int i = 0; i < 10; i++) begin
            step(1'b1, TBL[i][3], TBL[i][2]);
            exp_acc += int'(TBL[i][1]) - int'(TBL[i][0]);
            check("R2/R3/R4 early vote", int'(vote_early), int'(TBL[i][1]));
            check("R2/R3/R4 late vote", int'(vote_late), int'(TBL[i][0]));
            check("R2 R3 R4 accumulator", int'(ctrl_word), exp_acc);
            check("R6 retimed data", int'(dout), int'(TBL[i][2]));
        end
        check("R1 first set cast no vote, table sum", exp_acc, 1);

        // R5: an idle set that would otherwise vote late.
        step(1'b0, 1'b1, 1'b1);
        check("R5 no early when idle", int'(vote_early), 0);
        check("R5 no late when idle", int'(vote_late), 0);
        check("R5 ctrl held when idle", int'(ctrl_word), 1);
        check("R5 dout held when idle", int'(dout), 0);
        // The previous bit must still be 0: xing=0, curr=1 gives early.
        step(1'b1, 1'b0, 1'b1);
        check("R5 previous bit kept across gap", int'(vote_early), 1);
        check("R5 ctrl after gap", int'(ctrl_word), 2);
        step(1'b0, 1'b0, 1'b0);
        check("R10 pulse lasts one cycle", int'(vote_early), 0);

        // R7 saturation both ways.
        do_reset();
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 140; i++) bit_early();
        check("R7 positive rail", int'(ctrl_word), 127);
        check("R9 no flag at rail with limit 127", int'(ctrl_clamped), 0);
        bit_late();
        check("R7 no wrap leaving positive rail", int'(ctrl_word), 126);
        for (int i = 0; i < 260; i++) bit_late();
        check("R7 negative rail", int'(ctrl_word), -127);
        bit_early();
        check("R7 no wrap leaving negative rail", int'(ctrl_word), -126);

        // R9 clamp follows the limit combinationally.
        cfg_limit = 7'd5;
        #1;
        check("R9 clamped low", int'(ctrl_word), -5);
        check("R9 flag raised", int'(ctrl_clamped), 1);
        cfg_limit = 7'd127;
        #1;
        check("R9 unclamped value kept", int'(ctrl_word), -126);
        check("R9 flag cleared", int'(ctrl_clamped), 0);
        @(negedge clk);

        // R8 leak every 4th qualified set, shift 1.
        do_reset();
        cfg_leak_period = 6'd4;
        cfg_leak_shift  = 3'd1;
        step(1'b1, 1'b0, 1'b0);
        bit_early();
        bit_early();
        check("R8 before leak", int'(ctrl_word), 2);
        bit_early();
        check("R8 vote then leak 3->2", int'(ctrl_word), 2);
        bit_early();
        bit_early();
        bit_early();
        check("R8 no leak off cadence", int'(ctrl_word), 5);
        bit_early();
        check("R8 vote then leak 6->3", int'(ctrl_word), 3);
        cfg_leak_period = 6'd1;
        cfg_leak_shift  = 3'd0;
        bit_early();
        check("R8 shift 0 clears", int'(ctrl_word), 0);

        // R8 negative leak and period 0.
        do_reset();
        cfg_leak_period = 6'd0;
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) bit_late();
        check("R8 period 0 no leak", int'(ctrl_word), -5);
        cfg_leak_period = 6'd1;
        cfg_leak_shift  = 3'd1;
        bit_flat();
        check("R8 negative leak -5->-3", int'(ctrl_word), -3);
        check("R4 flat set casts no vote", int'({vote_early, vote_late}), 0);
        bit_flat();
        check("R8 negative leak -3->-2", int'(ctrl_word), -2);

        // R1 mid-run reset.
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears ctrl", int'(ctrl_word), 0);
        rst = 1'b0;
        cfg_leak_period = 6'd0;
        step(1'b1, 1'b1, 1'b1);
        check("R1 first set after reset no vote", int'({vote_early, vote_late}), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule